// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers interrupt requests from a set of on-chip modules and from a group of general-purpose input pins, and folds them onto one interrupt output line for a host. Each module source owns one bit in a top-level status register. The pin group is handled one level down: its own enable and status registers record which pin fired. Any enabled pending pin bit is summarized into a single top-level status bit, whose index is `N_MOD`. This is bit 8 with the default parameters. The host reads the top-level status first, follows the summary bit into the pin status register when it is set, and clears the bits it has handled by writing ones.

The output line is driven by a small state machine with four states. In `S_IDLE` the line is inactive. In `S_LEVEL` the line is held active. In `S_PULSE` the line is active for a fixed count of clocks. In `S_HOLD` the pulse has ended but requests are still pending. The transitions are as follows:

- `S_IDLE` goes to `S_LEVEL` or `S_PULSE` once a request is pending with the global enable set. Which of the two it enters depends on the mode bit.
- `S_LEVEL` and `S_HOLD` return to `S_IDLE` when nothing is pending or the enable drops.
- `S_PULSE` moves to `S_HOLD` when its count completes, or back to `S_IDLE` if the enable drops.
- A mode change moves `S_LEVEL` to `S_HOLD`, or `S_HOLD` to `S_LEVEL`.

A polarity bit selects whether active means high or low. A plain synchronous register port, with a write strobe and a combinational read, stands in for the host bus.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 1, because polarity 0 means active-low, so the inactive level is high.
- R2: The register map is as follows. Address 0 is the top enable (N_MOD+1 bits). Address 1 is the top status. Address 2 is the pin enable (N_GPIO bits). Address 3 is the pin status. Address 4 is control: bit 0 is the global enable, bit 1 is the mode (1 = pulse, 0 = level) and bit 2 is the polarity (1 = active-high). The enable and control registers read back what was written. Unassigned addresses and unused bits read 0.
- R3: A module status bit k is set at the clock edge where `mod_ev_i[k]` is seen high after being low on the previous edge, but only if top enable bit k is 1. While its enable is 0, a rising event leaves the bit at 0.
- R4: A write to a status register clears each bit where the data is 1 and leaves the bits where it is 0. When a set and a clear hit the same bit on the same edge, the bit ends up 1.
- R5: A pin status bit j is set on a rising `gpio_ev_i[j]` while pin enable bit j is 1. Top status bit N_MOD is set whenever any pin status bit with its enable is 1 and top enable bit N_MOD is 1.
- R6: A pin request is fully cleared by two writes of 1: one to its pin status bit and one to top status bit N_MOD. If the top bit is cleared while the pin bit is still pending, the top bit sets again.
- R7: In level mode with global enable, the output is active while any top status bit with its enable is 1. It goes inactive once all such bits are cleared.
- R8: In pulse mode the output is active for exactly PULSE_CYC = ceil(CLK_MHZ*PULSE_NS/1000) clocks. No further pulse is issued until the pending set has become empty and a new request arrives.
- R9: With global enable 0, the output stays inactive. Status bits are kept, and re-enabling with requests pending makes the output active again.
- R10: The inactive output level is the inverse of the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| mod_ev_i | input | N_MOD | Raw event lines from the other modules |
| gpio_ev_i | input | N_GPIO | Raw event lines from the pins |
| irq_o | output | 1 | Interrupt output line |

## Verification
The bench builds the block with 8 module sources, 16 pins, a 250 ns pulse and `CLK_MHZ` set to 250. With these values the pulse length works out to 62.5 clocks, so the round-up to 63 cycles is exercised rather than an exact division. Keeping the defaults of 8 module sources and 16 pins puts the summary bit at index 8 and fills the full 16-bit data path with pin bits. This lets the bench drive the highest pin and check that no unused bits leak into readback.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    typedef enum logic [2:0] {
        A_TOP_EN   = 3'd0,
        A_TOP_STS  = 3'd1,
        A_GPIO_EN  = 3'd2,
        A_GPIO_STS = 3'd3,
        A_CTRL     = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LEVEL,
        S_PULSE,
        S_HOLD
    } out_state_e;

    typedef struct packed {
        logic pol;
        logic pulse;
        logic gen;
    } ctrl_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       sts_o[i] <= 1'b0;
            else if (set_i[i]) sts_o[i] <= 1'b1;
            else if (clr_i[i]) sts_o[i] <= 1'b0;
        end
    end

    // R4: a set on the same edge as a clear leaves the bit at 1
    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));

    // R4: a clear with no set leaves the bit at 0
    p_w1c_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_i & ~set_i) != '0) |=> ((sts_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_cascade_pkg::*;
#(
    parameter int PULSE_CYC = 25,
    localparam int CW = $clog2(PULSE_CYC + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gen_i,
    input  logic pulse_mode_i,
    input  logic pol_i,
    input  logic pend_i,
    output logic irq_o
);
    out_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           active;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (gen_i && pend_i) state_d = pulse_mode_i ? S_PULSE : S_LEVEL;
            S_LEVEL: if (!(gen_i && pend_i)) state_d = S_IDLE;
                     else if (pulse_mode_i)  state_d = S_HOLD;
            S_PULSE: if (!gen_i)                         state_d = S_IDLE;
                     else if (cnt_q == CW'(PULSE_CYC-1)) state_d = S_HOLD;
            S_HOLD:  if (!(gen_i && pend_i)) state_d = S_IDLE;
                     else if (!pulse_mode_i) state_d = S_LEVEL;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == S_PULSE) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        active = (state_q == S_LEVEL) || (state_q == S_PULSE);
        irq_o  = pol_i ? active : ~active;
    end

    // R9: a dropped global enable makes the line inactive on the next edge
    p_gen_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gen_i |=> !active);

    // R7: level mode with enable and a pending request drives active
    p_level_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gen_i && pend_i && !pulse_mode_i) |=> active);

    // R8: no second pulse while requests stay pending
    p_no_repulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_HOLD && gen_i && pend_i && pulse_mode_i) |=> (state_q == S_HOLD));

    // R8: the pulse never runs past its length
    p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_PULSE) |-> (cnt_q < CW'(PULSE_CYC)));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int N_MOD    = 8,
    parameter int N_GPIO   = 16,
    parameter int CLK_MHZ  = 100,
    parameter int PULSE_NS = 250,
    localparam int N_TOP   = N_MOD + 1,
    localparam int DW_A    = (N_GPIO > N_TOP) ? N_GPIO : N_TOP,
    localparam int DW      = (DW_A > 3) ? DW_A : 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [N_MOD-1:0]  mod_ev_i,
    input  logic [N_GPIO-1:0] gpio_ev_i,
    output logic              irq_o
);
    localparam int GBIT      = N_MOD;
    localparam int PULSE_CYC = (CLK_MHZ * PULSE_NS + 999) / 1000;

    logic [N_TOP-1:0]  top_en_q, top_sts, top_set, top_clr;
    logic [N_GPIO-1:0] gpio_en_q, gpio_sts, gpio_set, gpio_clr, gpio_rise;
    logic [N_MOD-1:0]  mod_rise;
    ctrl_t             ctrl_q;
    logic              gpio_pend, top_pend;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_en_q  <= '0;
            gpio_en_q <= '0;
            ctrl_q    <= '0;
        end else if (wr_en_i) begin
            if (addr_i == A_TOP_EN)  top_en_q  <= wdata_i[N_TOP-1:0];
            if (addr_i == A_GPIO_EN) gpio_en_q <= wdata_i[N_GPIO-1:0];
            if (addr_i == A_CTRL)    ctrl_q    <= wdata_i[2:0];
        end
    end

    irq_edge_det #(.W(N_MOD)) u_mod_edge (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(mod_ev_i), .rise_o(mod_rise));
    irq_edge_det #(.W(N_GPIO)) u_gpio_edge (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(gpio_ev_i), .rise_o(gpio_rise));

    assign gpio_set  = gpio_rise & gpio_en_q;
    assign gpio_clr  = (wr_en_i && addr_i == A_GPIO_STS) ? wdata_i[N_GPIO-1:0] : '0;
    assign gpio_pend = |(gpio_sts & gpio_en_q);

    irq_status_bank #(.W(N_GPIO)) u_gpio_sts (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(gpio_set), .clr_i(gpio_clr), .sts_o(gpio_sts));

    assign top_set  = {gpio_pend & top_en_q[GBIT], mod_rise & top_en_q[N_MOD-1:0]};
    assign top_clr  = (wr_en_i && addr_i == A_TOP_STS) ? wdata_i[N_TOP-1:0] : '0;
    assign top_pend = |(top_sts & top_en_q);

    irq_status_bank #(.W(N_TOP)) u_top_sts (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(top_set), .clr_i(top_clr), .sts_o(top_sts));

    irq_out_fsm #(.PULSE_CYC(PULSE_CYC)) u_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .gen_i(ctrl_q.gen), .pulse_mode_i(ctrl_q.pulse),
        .pol_i(ctrl_q.pol), .pend_i(top_pend), .irq_o(irq_o));

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_TOP_EN:   rdata_o = DW'(top_en_q);
            A_TOP_STS:  rdata_o = DW'(top_sts);
            A_GPIO_EN:  rdata_o = DW'(gpio_en_q);
            A_GPIO_STS: rdata_o = DW'(gpio_sts);
            A_CTRL:     rdata_o = DW'(ctrl_q);
            default:    rdata_o = '0;
        endcase
    end

    // R5: an enabled pending pin raises the summary bit on the next edge
    p_gpio_summary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (top_en_q[GBIT] && gpio_pend) |=> top_sts[GBIT]);

    // R3: a disabled module source never sets its status bit
    p_mod_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(top_sts[N_MOD-1:0]) == '0 && !$past(wr_en_i) &&
         (top_sts[N_MOD-1:0] & ~$past(top_en_q[N_MOD-1:0])) != '0) |-> 1'b0);
endmodule

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
    localparam int N_MOD = 8, N_GPIO = 16, CLK_MHZ = 250, PULSE_NS = 250;
    localparam int EXP_PULSE = (CLK_MHZ * PULSE_NS + 999) / 1000;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic [N_MOD-1:0] mod_ev = '0;
    logic [N_GPIO-1:0] gpio_ev = '0;
    logic irq;
    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    irq_cascade_ctrl #(.N_MOD(N_MOD), .N_GPIO(N_GPIO), .CLK_MHZ(CLK_MHZ), .PULSE_NS(PULSE_NS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .mod_ev_i(mod_ev), .gpio_ev_i(gpio_ev), .irq_o(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d); chk("R1 reg after reset", d, 0);
        end
        chk("R1 irq after reset", irq, 1);
    endtask

    task automatic t_regs;
        logic [15:0] d;
        wr(0, 16'hFFFF); rd(0, d); chk("R2 top enable width", d, 16'h01FF);
        wr(2, 16'hA5C3); rd(2, d); chk("R2 pin enable", d, 16'hA5C3);
        wr(4, 16'hFFF8); rd(4, d); chk("R2 ctrl unused bits", d, 0);
        wr(4, 16'h0005); rd(4, d); chk("R2 ctrl readback", d, 5);
        rd(5, d); chk("R2 unassigned address", d, 0);
        wr(4, 0); wr(0, 0); wr(2, 0);
    endtask

    task automatic t_mod_level;
        logic [15:0] d;
        wr(4, 16'h0005); wr(0, 16'h0004);
        @(negedge clk); mod_ev[3] = 1'b1; mod_ev[2] = 1'b1;
        settle(3);
        rd(1, d); chk("R3 disabled source stays 0", d, 16'h0004);
        chk("R7 level active", irq, 1);
        wr(1, 16'h0000); rd(1, d); chk("R4 zero write keeps bit", d, 16'h0004);
        wr(1, 16'h0004); settle(2);
        rd(1, d); chk("R4 w1c clears", d, 0);
        chk("R7 level inactive after clear", irq, 0);
        mod_ev = '0; settle(1);
    endtask

    task automatic t_w1c_priority;
        logic [15:0] d;
        @(negedge clk); mod_ev[2] = 1'b1; wr_en = 1'b1; addr = 1; wdata = 16'h0004;
        @(negedge clk); wr_en = 1'b0;
        rd(1, d); chk("R4 set wins over clear", d, 16'h0004);
        wr(1, 16'h0004); rd(1, d); chk("R4 later clear", d, 0);
        mod_ev = '0; settle(2);
    endtask

    task automatic t_gpio_cascade;
        logic [15:0] d;
        wr(0, 16'h0100); wr(2, 16'h8000);
        @(negedge clk); gpio_ev[15] = 1'b1; gpio_ev[0] = 1'b1;
        settle(4);
        rd(3, d); chk("R5 pin status", d, 16'h8000);
        rd(1, d); chk("R5 summary bit 8", d, 16'h0100);
        chk("R5 irq from pin", irq, 1);
        wr(1, 16'h0100); settle(1);
        rd(1, d); chk("R6 summary resets while pin pending", d, 16'h0100);
        wr(3, 16'h8000); wr(1, 16'h0100); settle(2);
        rd(3, d); chk("R6 pin cleared", d, 0);
        rd(1, d); chk("R6 summary cleared", d, 0);
        chk("R6 irq released", irq, 0);
        gpio_ev = '0; wr(2, 0); settle(1);
    endtask

    task automatic t_pulse;
        int cnt;
        wr(4, 16'h0007); wr(0, 16'h0001);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); mod_ev[0] = 1'b1;
            cnt = 0;
            for (int c = 0; c < 150; c++) begin
                @(negedge clk); if (irq) cnt++;
            end
            chk("R8 single pulse width", cnt, EXP_PULSE);
            wr(1, 16'h0001); mod_ev[0] = 1'b0; settle(3);
            chk("R8 idle after clear", irq, 0);
        end
    endtask

    task automatic t_global_en;
        logic [15:0] d;
        wr(4, 16'h0005);
        @(negedge clk); mod_ev[0] = 1'b1; settle(3);
        chk("R9 active before disable", irq, 1);
        wr(4, 16'h0004); settle(1);
        chk("R9 inactive when disabled", irq, 0);
        rd(1, d); chk("R9 status kept", d, 16'h0001);
        wr(4, 16'h0005); settle(1);
        chk("R9 active after re-enable", irq, 1);
        wr(1, 16'h0001); mod_ev = '0; settle(2);
    endtask

    task automatic t_polarity;
        wr(4, 16'h0001); settle(1);
        chk("R10 active-low idle high", irq, 1);
        @(negedge clk); mod_ev[0] = 1'b1; settle(3);
        chk("R10 active-low asserted", irq, 0);
        wr(1, 16'h0001); settle(2);
        chk("R10 active-low released", irq, 1);
        mod_ev = '0; wr(4, 16'h0004); settle(1);
        chk("R10 disabled active-high idles low", irq, 0);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_mod_level;
        t_w1c_priority;
        t_gpio_cascade;
        t_pulse;
        t_global_en;
        t_polarity;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule